// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block controls a bank of 32 general-purpose pins from a plain 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. For every pin the block holds a drive-enable bit and an output level bit, and it samples the pin level so that software can read it. The pad cells sit outside the block. It hands them three vectors: output level, drive enable and sampled input.

Software never has to read, modify and write a register. Direction is changed through two registers: one sets the enable bits that are written as 1, the other clears them. Output levels are written one half of the bank at a time. In that write, the upper half of the data word is a per-bit mask that chooses which of the lower value bits take effect. The output level is kept while a pin is an input, so software can load a level first and then turn the driver on without a glitch.

Top module: `gpio_mask_bank`

## Requirements
- R1: While reset is held, and at the first clock after it is released, every drive-enable bit and every output-level bit is 0.
- R2: A write to address 0x00 sets the drive-enable bit of each pin whose data bit is 1. Pins whose data bit is 0 keep their enable bit.
- R3: A write to address 0x04 clears the drive-enable bit of each pin whose data bit is 1. Pins whose data bit is 0 keep their enable bit.
- R4: A write to address 0x08 updates pins 0 to 15. Data bit 16+k is a mask for pin k, and pin k takes data bit k only when that mask bit is 1. Pins 16 to 31 do not change, and a write with an all-zero mask changes nothing.
- R5: A write to address 0x0C updates pins 16 to 31 in the same way: data bit 16+k masks data bit k, which goes to pin 16+k. Pins 0 to 15 do not change.
- R6: The output level of a pin changes only through writes to 0x08 or 0x0C. Setting or clearing its drive enable leaves the level as it was, and a level written while the pin is an input appears on the pin as soon as its driver is turned on.
- R7: A read of address 0x10 returns the pin inputs as they were two clock edges earlier, through a two-stage synchronizer. A change is not visible after one edge and is visible after two.
- R8: A read of address 0x00 or 0x04 returns the drive-enable vector. A read of 0x08 returns pins 0 to 15 and a read of 0x0C returns pins 16 to 31, each in bits 15:0 with bits 31:16 equal to 0.
- R9: A write to any address other than 0x00, 0x04, 0x08 and 0x0C changes neither vector, and a read of any address other than the five listed returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Byte address of the register being read or written |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wr_data | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Levels seen at the pads |
| pin_out | output | 32 | Output level for each pad |
| pin_oe | output | 32 | Drive enable for each pad (1 = output) |

## Verification
The case that is hardest to reach from the ports is a masked half-bank write landing on a partly loaded output word. Here the mask, the new value bits and the old level all differ, and the other half must stay put. The bench reaches it with a long pseudo-random run of writes to every address, including unaligned and unmapped ones. A bench model tracks both vectors arithmetically, and the bench compares the pad vectors and every readable register after each write. Synchronizer latency is measured by changing the pins at a falling edge and reading back after one and after two rising edges.

// File: rtl/gpio_mask_pkg.sv
`timescale 1ns/1ps
package gpio_mask_pkg;
  localparam int unsigned REG_ADDR_W = 8;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_OE_SET = 8'h00,
    A_OE_CLR = 8'h04,
    A_OUT_LO = 8'h08,
    A_OUT_HI = 8'h0C,
    A_PIN_IN = 8'h10
  } gpio_reg_e;

  typedef struct packed {
    logic oe_set;
    logic oe_clr;
    logic out_lo;
    logic out_hi;
  } gpio_wr_dec_t;
endpackage

// File: rtl/gpio_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of the active-low reset.
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_dir_reg.sv
`timescale 1ns/1ps
// Drive-enable vector with write-one-to-set and write-one-to-clear ports.
module gpio_dir_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] oe_q
);
  logic [WIDTH-1:0] oe_d;
  logic             oe_ce;

  always_comb begin
    oe_d  = oe_q;
    oe_ce = set_en | clr_en;
    if (set_en) begin
      oe_d = oe_q | wdata;
    end else if (clr_en) begin
      oe_d = oe_q & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= '0;
    end else if (oe_ce) begin
      oe_q <= oe_d;
    end
  end
endmodule

// File: rtl/gpio_half_out.sv
`timescale 1ns/1ps
// One half-bank of output levels; the upper half of the write word masks the lower half.
module gpio_half_out #(
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [HALF_W-1:0] val_q
);
  logic [HALF_W-1:0] mask;
  logic [HALF_W-1:0] newv;
  logic [HALF_W-1:0] val_d;
  logic              val_ce;

  always_comb begin
    mask   = wdata[WORD_W-1:HALF_W];
    newv   = wdata[HALF_W-1:0];
    val_d  = (val_q & ~mask) | (newv & mask);
    val_ce = wr_en & (|mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_ce) begin
      val_q <= val_d;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for the pad input levels.
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = d_i;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mask_bank.sv
`timescale 1ns/1ps
module gpio_mask_bank
  import gpio_mask_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr_en,
  input  logic [NUM_PINS-1:0]   bus_wr_data,
  output logic [NUM_PINS-1:0]   bus_rd_data,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pin_out,
  output logic [NUM_PINS-1:0]   pin_oe
);
  localparam int unsigned HALF_W  = NUM_PINS / 2;
  localparam int unsigned N_HALVES = 2;

  logic                rst_sync_n;
  gpio_wr_dec_t        wr_dec;
  logic [N_HALVES-1:0] half_wr;
  logic [NUM_PINS-1:0] oe_q;
  logic [NUM_PINS-1:0] out_q;
  logic [NUM_PINS-1:0] in_q;

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Write decode: exact address match only.
  always_comb begin
    wr_dec.oe_set = bus_wr_en & (bus_addr == A_OE_SET);
    wr_dec.oe_clr = bus_wr_en & (bus_addr == A_OE_CLR);
    wr_dec.out_lo = bus_wr_en & (bus_addr == A_OUT_LO);
    wr_dec.out_hi = bus_wr_en & (bus_addr == A_OUT_HI);
    half_wr       = {wr_dec.out_hi, wr_dec.out_lo};
  end

  gpio_dir_reg #(.WIDTH(NUM_PINS)) u_dir (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_en (wr_dec.oe_set),
    .clr_en (wr_dec.oe_clr),
    .wdata  (bus_wr_data),
    .oe_q   (oe_q)
  );

  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    gpio_half_out #(.HALF_W(HALF_W)) u_out (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .wr_en (half_wr[h]),
      .wdata (bus_wr_data),
      .val_q (out_q[h*HALF_W +: HALF_W])
    );
  end

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (pin_in),
    .q_o   (in_q)
  );

  // Read path.
  always_comb begin
    bus_rd_data = '0;
    case (bus_addr)
      A_OE_SET, A_OE_CLR: bus_rd_data = oe_q;
      A_OUT_LO:           bus_rd_data = {{HALF_W{1'b0}}, out_q[HALF_W-1:0]};
      A_OUT_HI:           bus_rd_data = {{HALF_W{1'b0}}, out_q[NUM_PINS-1:HALF_W]};
      A_PIN_IN:           bus_rd_data = in_q;
      default:            bus_rd_data = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = oe_q;
endmodule

// File: rtl/gpio_mask_bank_chk.sv
`timescale 1ns/1ps
module gpio_mask_bank_chk #(
  parameter int unsigned NUM_PINS = 32,
  localparam int unsigned H = NUM_PINS / 2
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic [7:0]          bus_addr,
  input logic                bus_wr_en,
  input logic [NUM_PINS-1:0] bus_wr_data,
  input logic [NUM_PINS-1:0] bus_rd_data,
  input logic [NUM_PINS-1:0] pin_in,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);
  logic [1:0] live_cnt;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      live_cnt <= '0;
    end else if (live_cnt != 2'd3) begin
      live_cnt <= live_cnt + 2'd1;
    end
  end

  logic wr_set, wr_clr, wr_lo, wr_hi;
  assign wr_set = bus_wr_en && bus_addr == 8'h00;
  assign wr_clr = bus_wr_en && bus_addr == 8'h04;
  assign wr_lo  = bus_wr_en && bus_addr == 8'h08;
  assign wr_hi  = bus_wr_en && bus_addr == 8'h0C;

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (pin_oe == '0 && pin_out == '0));

  p_oe_set_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_set |=> pin_oe == ($past(pin_oe) | $past(bus_wr_data)));

  p_oe_clr_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_clr |=> pin_oe == ($past(pin_oe) & ~$past(bus_wr_data)));

  p_out_lo_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_lo |=> (pin_out[H-1:0] ==
               (($past(pin_out[H-1:0]) & ~$past(bus_wr_data[NUM_PINS-1:H])) |
                ($past(bus_wr_data[H-1:0]) & $past(bus_wr_data[NUM_PINS-1:H]))))
              && $stable(pin_out[NUM_PINS-1:H]));

  p_out_hi_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_hi |=> (pin_out[NUM_PINS-1:H] ==
               (($past(pin_out[NUM_PINS-1:H]) & ~$past(bus_wr_data[NUM_PINS-1:H])) |
                ($past(bus_wr_data[H-1:0]) & $past(bus_wr_data[NUM_PINS-1:H]))))
              && $stable(pin_out[H-1:0]));

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_lo || wr_hi) |=> $stable(pin_out));

  p_in_latency_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live_cnt >= 2'd2 && bus_addr == 8'h10) |-> bus_rd_data == $past(pin_in, 2));

  p_rd_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == 8'h08 || bus_addr == 8'h0C) |-> bus_rd_data[NUM_PINS-1:H] == '0);

  p_oe_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_set || wr_clr) |=> $stable(pin_oe));
endmodule

bind gpio_mask_bank gpio_mask_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .bus_addr    (bus_addr),
  .bus_wr_en   (bus_wr_en),
  .bus_wr_data (bus_wr_data),
  .bus_rd_data (bus_rd_data),
  .pin_in      (pin_in),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe)
);

// File: tb/gpio_mask_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_mask_bank_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr_en;
  logic [31:0] bus_wr_data;
  logic [31:0] bus_rd_data;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int n_chk;
  int n_err;
  bit done;

  logic [31:0] m_oe;
  logic [31:0] m_out;
  logic [31:0] lfsr;

  gpio_mask_bank dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_data (bus_rd_data),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rd_data;
  endtask

  // Bench model of one register write.
  task automatic model(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h00: m_oe = m_oe | d;
      8'h04: m_oe = m_oe & ~d;
      8'h08: m_out[15:0]  = (m_out[15:0]  & ~d[31:16]) | (d[15:0] & d[31:16]);
      8'h0C: m_out[31:16] = (m_out[31:16] & ~d[31:16]) | (d[15:0] & d[31:16]);
      default: ;
    endcase
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr    = a;
    bus_wr_data = d;
    bus_wr_en   = 1'b1;
    tick();
    bus_wr_en   = 1'b0;
    model(a, d);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] r;
    chk({tag, " pin_oe"},  pin_oe,  m_oe);
    chk({tag, " pin_out"}, pin_out, m_out);
    rd(8'h00, r); chk({tag, " R8 rd 0x00"}, r, m_oe);
    rd(8'h04, r); chk({tag, " R8 rd 0x04"}, r, m_oe);
    rd(8'h08, r); chk({tag, " R8 rd 0x08"}, r, {16'h0, m_out[15:0]});
    rd(8'h0C, r); chk({tag, " R8 rd 0x0C"}, r, {16'h0, m_out[31:16]});
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], 1'b0} ^ (s[31] ? 32'h04C1_1DB7 : 32'h0);
  endfunction

  initial begin
    logic [31:0] r;
    logic [31:0] prev;
    n_chk = 0; n_err = 0; done = 1'b0;
    m_oe = '0; m_out = '0;
    bus_addr = '0; bus_wr_en = 1'b0; bus_wr_data = '0; pin_in = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: writes during reset have no effect, state is zero
    bus_addr = 8'h00; bus_wr_data = 32'hFFFF_FFFF; bus_wr_en = 1'b1;
    tick();
    bus_wr_en = 1'b0;
    chk("R1 oe in reset",  pin_oe,  32'h0);
    chk("R1 out in reset", pin_out, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 oe after release",  pin_oe,  32'h0);
    chk("R1 out after release", pin_out, 32'h0);
    repeat (3) tick();
    check_all("R1");

    // R2: walking set
    for (int i = 0; i < 32; i++) begin
      wr(8'h00, 32'h1 << i);
      chk("R2 walking set", pin_oe, m_oe);
    end
    // R3: walking clear of every other pin, then the rest
    for (int i = 0; i < 32; i += 2) begin
      wr(8'h04, 32'h1 << i);
      chk("R3 walking clear", pin_oe, m_oe);
    end
    wr(8'h04, 32'hFFFF_FFFF);
    chk("R3 clear all", pin_oe, 32'h0);

    // R4/R5: walking mask bits per half
    for (int k = 0; k < 16; k++) begin
      wr(8'h08, (32'h1 << (16 + k)) | 32'h0000_FFFF);
      chk("R4 walking mask lo", pin_out, m_out);
      wr(8'h0C, (32'h1 << (16 + k)) | (32'h1 << k));
      chk("R5 walking mask hi", pin_out, m_out);
    end
    wr(8'h08, 32'h0000_0000);
    check_all("R4 zero mask no change");
    wr(8'h08, 32'h0000_FFFF);
    check_all("R4 zero mask with values");
    wr(8'h0C, 32'h0000_1234);
    check_all("R5 zero mask with values");

    // R6: level loaded while input survives enable and disable
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_A5C3);
    wr(8'h0C, 32'hFFFF_3C5A);
    chk("R6 level loaded while input", pin_out, 32'h3C5A_A5C3);
    wr(8'h00, 32'hFFFF_FFFF);
    chk("R6 level kept on enable", pin_out, 32'h3C5A_A5C3);
    chk("R6 oe on", pin_oe, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0F0F_0F0F);
    chk("R6 level kept on disable", pin_out, 32'h3C5A_A5C3);

    // R9: writes to input, unaligned and unmapped addresses
    wr(8'h10, 32'hFFFF_FFFF); check_all("R9 write 0x10");
    wr(8'h14, 32'hFFFF_0000); check_all("R9 write 0x14");
    wr(8'h01, 32'hFFFF_FFFF); check_all("R9 write 0x01");
    wr(8'h09, 32'hFFFF_0000); check_all("R9 write 0x09");
    wr(8'hFC, 32'hFFFF_FFFF); check_all("R9 write 0xFC");
    rd(8'h14, r); chk("R9 read 0x14", r, 32'h0);
    rd(8'h02, r); chk("R9 read 0x02", r, 32'h0);
    rd(8'hFC, r); chk("R9 read 0xFC", r, 32'h0);

    // Mixed pseudo-random sweep over all addresses
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      lfsr = step(lfsr);
      case (lfsr[2:0])
        3'd0: a = 8'h00;
        3'd1: a = 8'h04;
        3'd2, 3'd6: a = 8'h08;
        3'd3, 3'd7: a = 8'h0C;
        3'd4: a = 8'h10;
        default: a = 8'h0E;
      endcase
      lfsr = step(lfsr);
      wr(a, lfsr);
      check_all("R2 R3 R4 R5 R9 sweep");
    end

    // R7: input synchronizer latency
    pin_in = 32'h0;
    repeat (3) tick();
    prev = 32'h0;
    for (int i = 0; i < 34; i++) begin
      logic [31:0] v;
      v = (i < 32) ? (32'h1 << i) ^ 32'h8000_0001 : (i == 32 ? 32'hFFFF_FFFF : 32'h1234_5678);
      pin_in = v;
      bus_addr = 8'h10;
      tick();
      rd(8'h10, r); chk("R7 not visible after one edge", r, prev);
      tick();
      rd(8'h10, r); chk("R7 visible after two edges", r, v);
      prev = v;
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule